// File: doc/BRIEF.md
# Windowed Command and Interrupt-Status Register

This unit is the host-facing control point of a network adapter. The host issues every action as one 16-bit command word. The upper five bits hold an opcode and the lower eleven bits hold an argument. The commands cover register-window selection, interrupt acknowledge, loading the two masks, a software interrupt request, enabling and disabling the transmitter and receiver, and resets. The unit returns a 16-bit status word that is valid in any window. This word reports the selected window, a command-busy flag and the latched interrupt sources.

The transmit and receive logic sends one-cycle event pulses. Each pulse sets a sticky status bit, and the bit stays set until the host acknowledges it. An interrupt line is raised while any enabled source is latched. A separate read mask decides which latched bits the host can see in the status word.

Top module: `cmdStatusRegs`

## Requirements
- R1: After reset the status word is 0x0000, the interrupt output is low, and both the receiver and the transmitter are disabled.
- R2: Opcode 1 loads the window from argument bits 2..0, and argument bits 10..3 are ignored. Status bits 15..13 show the selected window from the cycle after the write.
- R3: Status bit 12 (busy) is high for exactly 4 cycles after a write with opcode 0, 5 or 11. It is high for exactly 1 cycle after a write with any other opcode. A new write restarts the count.
- R4: Each event pulse sets its latched status bit, and the bit stays set until it is acknowledged. The mapping is: adapter failure to bit 1, transmit done to bit 2, transmit available to bit 3, receive done to bit 4, receive early to bit 5, statistics due to bit 7.
- R5: Opcode 13 clears every latched bit whose argument bit (7..0) is 1 and leaves the other bits alone. An event or interrupt arriving in the same cycle keeps its bit set.
- R6: Opcode 15 loads argument bits 7..0 as the read mask. Status bits 7..0 show the latched bits ANDed with this mask. The mask does not affect the latches or the interrupt.
- R7: Opcode 14 loads argument bits 7..0 as the interrupt mask. The interrupt output is high while any of latched bits 7..1 is set together with its mask bit. Latched bit 0 sets on the cycle after the interrupt output is high.
- R8: Opcode 12 sets latched bit 6.
- R9: Opcode 4 enables the receiver and opcode 3 disables it. Opcode 9 enables the transmitter and opcode 10 disables it.
- R10: Opcode 0 sets the window to 0, clears all latches and both masks, and disables the receiver and the transmitter.
- R11: Opcodes with no defined action (for example 2, 8 and 16) change nothing except the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command write strobe |
| cmdWord | input | 16 | Opcode in bits 15..11, argument in bits 10..0 |
| failPulse | input | 1 | Adapter failure event |
| txDonePulse | input | 1 | Transmit complete event |
| txAvailPulse | input | 1 | Transmit space available event |
| rxDonePulse | input | 1 | Receive complete event |
| rxEarlyPulse | input | 1 | Early receive event |
| statsPulse | input | 1 | Statistics update due event |
| statusWord | output | 16 | Window, busy flag and masked latched bits |
| irqOut | output | 1 | Interrupt request |
| rxEnabled | output | 1 | Receiver enable state |
| txEnabled | output | 1 | Transmitter enable state |

## Verification
Every register result appears exactly one clock edge after the command or event that causes it. This holds for the window, the latches, the masks and the enables. The interrupt output follows combinationally from those registers, so it is due in the same cycle, and latched bit 0 follows one edge later. The busy flag rises at the write edge and stays high for 4 samples or 1 sample. The bench drives inputs on the falling edge and updates its reference model at the rising edge. It compares all outputs at the next falling edge, so each result is checked in the cycle where it is due.

// File: rtl/cmdStatusPkg.sv
package cmdStatusPkg;
  parameter int OP_W   = 5;
  parameter int ARG_W  = 11;
  parameter int WIN_W  = 3;
  parameter int STAT_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_GLOBAL_RESET = 5'd0,
    OP_WINDOW       = 5'd1,
    OP_RX_OFF       = 5'd3,
    OP_RX_ON        = 5'd4,
    OP_RX_RESET     = 5'd5,
    OP_TX_ON        = 5'd9,
    OP_TX_OFF       = 5'd10,
    OP_TX_RESET     = 5'd11,
    OP_SW_IRQ       = 5'd12,
    OP_ACK          = 5'd13,
    OP_INT_MASK     = 5'd14,
    OP_READ_MASK    = 5'd15
  } opcode_e;

  typedef struct packed {
    logic             globalReset;
    logic             winLoad;
    logic             rxOn;
    logic             rxOff;
    logic             txOn;
    logic             txOff;
    logic             ack;
    logic             swIrq;
    logic             intMaskLoad;
    logic             readMaskLoad;
    logic [ARG_W-1:0] arg;
  } cmdStrobes_t;
endpackage

// File: rtl/cmdCtrl.sv
module cmdCtrl
  import cmdStatusPkg::*;
#(
  parameter int RESET_BUSY  = 4,
  parameter int NORMAL_BUSY = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [OP_W+ARG_W-1:0]  cmdWord,
  output cmdStrobes_t            strobes,
  output logic                   busy
);
  localparam int CNT_W = $clog2(RESET_BUSY + 1);

  logic [OP_W-1:0] op;
  logic            isResetOp;
  logic [CNT_W-1:0] busyCnt;

  assign op = cmdWord[OP_W+ARG_W-1:ARG_W];
  assign isResetOp = (op == OP_GLOBAL_RESET) || (op == OP_RX_RESET) || (op == OP_TX_RESET);

  always_comb begin
    strobes     = '0;
    strobes.arg = cmdWord[ARG_W-1:0];
    if (cmdValid) begin
      case (op)
        OP_GLOBAL_RESET: strobes.globalReset  = 1'b1;
        OP_WINDOW:       strobes.winLoad      = 1'b1;
        OP_RX_OFF:       strobes.rxOff        = 1'b1;
        OP_RX_ON:        strobes.rxOn         = 1'b1;
        OP_TX_ON:        strobes.txOn         = 1'b1;
        OP_TX_OFF:       strobes.txOff        = 1'b1;
        OP_SW_IRQ:       strobes.swIrq        = 1'b1;
        OP_ACK:          strobes.ack          = 1'b1;
        OP_INT_MASK:     strobes.intMaskLoad  = 1'b1;
        OP_READ_MASK:    strobes.readMaskLoad = 1'b1;
        default:         ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      busyCnt <= '0;
    else if (cmdValid)
      busyCnt <= isResetOp ? CNT_W'(RESET_BUSY) : CNT_W'(NORMAL_BUSY);
    else if (busyCnt != '0)
      busyCnt <= busyCnt - 1'b1;
  end

  assign busy = (busyCnt != '0);

  // R3: a reset-type command loads the long busy window
  assert_busy_long_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && isResetOp) |=> (busyCnt == CNT_W'(RESET_BUSY)));
  // R3: with no new command, busy never restarts once low
  assert_busy_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && !busy) |=> !busy);
endmodule

// File: rtl/cmdDatapath.sv
module cmdDatapath
  import cmdStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobes_t       st,
  input  logic [STAT_W-1:0] evtVec,
  output logic [WIN_W-1:0]  window,
  output logic [STAT_W-1:0] visibleBits,
  output logic              irqOut,
  output logic              rxEnabled,
  output logic              txEnabled
);
  logic [STAT_W-1:0] latched, intMask, readMask, ackMask, setMask;
  logic [ARG_W-STAT_W-1:0] unusedArgBits;

  assign unusedArgBits = st.arg[ARG_W-1:STAT_W];
  assign irqOut  = |(latched[STAT_W-1:1] & intMask[STAT_W-1:1]);
  assign ackMask = st.ack ? st.arg[STAT_W-1:0] : '0;

  always_comb begin
    setMask    = evtVec;
    setMask[0] = setMask[0] | irqOut;
    setMask[6] = setMask[6] | st.swIrq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || 1'b0) begin
      window    <= '0;
      latched   <= '0;
      intMask   <= '0;
      readMask  <= '0;
      rxEnabled <= 1'b0;
      txEnabled <= 1'b0;
    end else if (st.globalReset) begin
      window    <= '0;
      latched   <= '0;
      intMask   <= '0;
      readMask  <= '0;
      rxEnabled <= 1'b0;
      txEnabled <= 1'b0;
    end else begin
      if (st.winLoad)      window   <= st.arg[WIN_W-1:0];
      if (st.intMaskLoad)  intMask  <= st.arg[STAT_W-1:0];
      if (st.readMaskLoad) readMask <= st.arg[STAT_W-1:0];
      if (st.rxOn)         rxEnabled <= 1'b1;
      else if (st.rxOff)   rxEnabled <= 1'b0;
      if (st.txOn)         txEnabled <= 1'b1;
      else if (st.txOff)   txEnabled <= 1'b0;
      latched <= (latched & ~ackMask) | setMask;
    end
  end

  assign visibleBits = latched & readMask;

  // R2: window only moves on a select or a global reset
  assert_window_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(st.winLoad || st.globalReset) |=> $stable(window));
  // R7: a raised interrupt is recorded in bit 0
  assert_irq_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !st.globalReset) |=> latched[0]);
  // R8: software request sets bit 6
  assert_sw_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.swIrq) |=> latched[6]);
  // R9: receiver enable takes effect
  assert_rx_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxOn && !st.globalReset) |=> rxEnabled);
endmodule

// File: rtl/cmdStatusRegs.sv
module cmdStatusRegs
  import cmdStatusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdWord,
  input  logic        failPulse,
  input  logic        txDonePulse,
  input  logic        txAvailPulse,
  input  logic        rxDonePulse,
  input  logic        rxEarlyPulse,
  input  logic        statsPulse,
  output logic [15:0] statusWord,
  output logic        irqOut,
  output logic        rxEnabled,
  output logic        txEnabled
);
  localparam int PAD_W = 16 - WIN_W - 1 - STAT_W;

  cmdStrobes_t       strobes;
  logic              busy;
  logic [WIN_W-1:0]  window;
  logic [STAT_W-1:0] visibleBits;
  logic [STAT_W-1:0] evtVec;

  assign evtVec = {statsPulse, 1'b0, rxEarlyPulse, rxDonePulse,
                   txAvailPulse, txDonePulse, failPulse, 1'b0};

  cmdCtrl #(.RESET_BUSY(4), .NORMAL_BUSY(1)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .strobes(strobes), .busy(busy)
  );

  cmdDatapath u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .evtVec(evtVec),
    .window(window), .visibleBits(visibleBits), .irqOut(irqOut),
    .rxEnabled(rxEnabled), .txEnabled(txEnabled)
  );

  assign statusWord = {window, busy, {PAD_W{1'b0}}, visibleBits};
endmodule

// File: tb/cmdStatusRegs_bench.sv
module cmdStatusRegs_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [5:0] evt = '0;
  logic [15:0] statusWord;
  logic irqOut, rxEnabled, txEnabled;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] mWin;
  logic [7:0] mLat, mIm, mRm;
  logic mRx, mTx;
  int mBusy;

  always #4 clk = ~clk;

  cmdStatusRegs u_cmdStatusRegs (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .failPulse(evt[0]), .txDonePulse(evt[1]), .txAvailPulse(evt[2]),
    .rxDonePulse(evt[3]), .rxEarlyPulse(evt[4]), .statsPulse(evt[5]),
    .statusWord(statusWord), .irqOut(irqOut), .rxEnabled(rxEnabled),
    .txEnabled(txEnabled)
  );

  function automatic logic modelIrq();
    return |(mLat[7:1] & mIm[7:1]);
  endfunction

  function automatic logic [18:0] expected();
    return {modelIrq(), mRx, mTx, mWin, (mBusy != 0), 4'b0, mLat & mRm};
  endfunction

  function automatic logic [7:0] evtToBits(input logic [5:0] e);
    return {e[5], 1'b0, e[4], e[3], e[2], e[1], e[0], 1'b0};
  endfunction

  task automatic modelReset();
    mWin = '0; mLat = '0; mIm = '0; mRm = '0; mRx = 0; mTx = 0; mBusy = 0;
  endtask

  task automatic modelEdge(input logic v, input logic [15:0] w, input logic [5:0] e);
    logic [4:0] op;
    logic [10:0] arg;
    logic irqOld;
    op = w[15:11]; arg = w[10:0]; irqOld = modelIrq();
    if (v) mBusy = (op == 0 || op == 5 || op == 11) ? 4 : 1;
    else if (mBusy > 0) mBusy = mBusy - 1;
    if (v && op == 0) begin
      mWin = '0; mLat = '0; mIm = '0; mRm = '0; mRx = 0; mTx = 0;
    end else begin
      if (v) begin
        case (op)
          5'd1:  mWin = arg[2:0];
          5'd3:  mRx = 0;
          5'd4:  mRx = 1;
          5'd9:  mTx = 1;
          5'd10: mTx = 0;
          5'd13: mLat = mLat & ~arg[7:0];
          5'd14: mIm = arg[7:0];
          5'd15: mRm = arg[7:0];
          default: ;
        endcase
        if (op == 12) mLat[6] = 1'b1;
      end
      mLat = mLat | evtToBits(e);
      if (irqOld) mLat[0] = 1'b1;
    end
  endtask

  task automatic compare(input string tag);
    logic [18:0] act, exp;
    act = {irqOut, rxEnabled, txEnabled, statusWord};
    exp = expected();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {irq,rx,tx,status} actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge: drive, take the rising edge, compare at next falling edge
  task automatic cycle(input string tag, input logic v, input logic [15:0] w, input logic [5:0] e);
    cmdValid = v; cmdWord = w; evt = e;
    @(posedge clk);
    modelEdge(v, w, e);
    @(negedge clk);
    cmdValid = 0; cmdWord = '0; evt = '0;
    compare(tag);
  endtask

  task automatic cmd(input string tag, input int op, input int arg);
    cycle(tag, 1'b1, {5'(op), 11'(arg)}, 6'd0);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cycle(tag, 1'b0, 16'd0, 6'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: window select, upper argument bits ignored
    cmd("R2", 1, 11'h7FD);
    cmd("R2", 1, 11'h002);
    // R3: long busy after a transmit reset, restart by new write
    cmd("R3", 11, 0);
    idle("R3", 5);
    cmd("R3", 5, 0);
    idle("R3", 2);
    cmd("R3", 1, 3);
    idle("R3", 2);
    // R6: open read mask, then R4 event latches
    cmd("R6", 15, 8'hFF);
    cycle("R4", 1'b0, 16'd0, 6'b111111);
    idle("R4", 2);
    // R5: partial acknowledge, and event coinciding with ack of same bit
    cmd("R5", 13, 8'h06);
    cycle("R5", 1'b1, {5'd13, 11'h010}, 6'b001000);
    // R6: narrow read mask hides bits but keeps latches
    cmd("R6", 15, 8'h0F);
    cmd("R6", 15, 8'hFF);
    // R7: interrupt mask and bit 0
    cmd("R7", 14, 8'h80);
    idle("R7", 2);
    cmd("R7", 13, 8'h81);
    idle("R7", 2);
    // R8: software interrupt request
    cmd("R8", 12, 0);
    cmd("R8", 14, 8'h40);
    idle("R8", 2);
    // R9: enables
    cmd("R9", 4, 0);
    cmd("R9", 9, 0);
    cmd("R9", 3, 0);
    cmd("R9", 4, 0);
    // R11: undefined opcodes
    cmd("R11", 2, 11'h7FF);
    cmd("R11", 8, 11'h7FF);
    cmd("R11", 16, 11'h7FF);
    // R10: global reset
    cmd("R10", 0, 11'h7FF);
    idle("R10", 4);

    // random mix
    cmd("R6", 15, 8'hFF);
    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic [4:0] op;
      logic [5:0] e;
      logic v;
      pick = int'($urandom_range(0, 15));
      case (pick)
        0: op = 5'd1;  1: op = 5'd3;  2: op = 5'd4;  3: op = 5'd9;
        4: op = 5'd10; 5: op = 5'd12; 6: op = 5'd13; 7: op = 5'd13;
        8: op = 5'd14; 9: op = 5'd15; 10: op = 5'd2; 11: op = 5'd5;
        12: op = 5'd11; 13: op = 5'd8;
        14: op = ($urandom_range(0, 9) == 0) ? 5'd0 : 5'd15;
        default: op = 5'(($urandom_range(16, 31)));
      endcase
      v = ($urandom_range(0, 2) == 0);
      e = 6'($urandom) & 6'($urandom);
      cycle("R4", v, {op, 11'($urandom)}, e);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule